// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This unit performs one field operation per strobe on a 32-bit operand. A field is a run of contiguous bits named by a width and an offset. The offset is counted upward from bit 0 at the least significant end. The descriptor can arrive in either of two ways: as two separate immediate inputs, or packed into one 10-bit descriptor word of the kind a register would hold.

Five operations are available:
- a flag-only test, which leaves the operand unchanged;
- clearing the field;
- setting the field;
- extracting the field to bit 0 with zero fill;
- extracting the field to bit 0 with its top bit copied upward.

The result word and a zero flag are registered. They appear one clock after the strobe, together with a result-valid pulse.

Top module: `bitfield_unit`

## Requirements
- R1: A synchronous active-low reset drives `out_valid`, `result` and `zero_flag` to 0 on the clock edge where `rst_n` is sampled low.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. When no strobe is given, `result` and `zero_flag` hold their previous values.
- R3: With `desc_sel`=1, the offset is taken from `field_desc[4:0]` and the width code from `field_desc[9:5]`, and the immediates are ignored. With `desc_sel`=0, `imm_offset` and `imm_width` are used and `field_desc` is ignored.
- R4: The field covers bit positions offset through offset+width-1, with offset 0 meaning the least significant bit. A width code of 0 means 32 bits. Width 5 at offset 10 names bits 14..10.
- R5: Any field bits that would lie above bit 31 are dropped, so the field ends at bit 31.
- R6: Op code 0 (test) returns the operand unchanged in `result`.
- R7: Op code 1 (clear) returns the operand with every field bit forced to 0 and all other bits unchanged.
- R8: Op code 2 (set) returns the operand with every field bit forced to 1 and all other bits unchanged.
- R9: Op code 3 (unsigned extract) returns the field shifted down to bit 0, with all bits above it set to 0.
- R10: Op code 4 (signed extract) returns the field shifted down to bit 0, with every bit above it equal to the field's highest bit that remains after truncation.
- R11: For every op code, `zero_flag` is 1 exactly when all field bits of the incoming operand are 0.
- R12: Op codes 5, 6 and 7 behave exactly like op code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| operand | input | 32 | Operand word |
| desc_sel | input | 1 | 1: use packed descriptor, 0: use immediates |
| imm_width | input | 5 | Immediate width code (0 = 32) |
| imm_offset | input | 5 | Immediate offset from bit 0 |
| field_desc | input | 10 | Packed descriptor: width code [9:5], offset [4:0] |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 32 | Registered result word |
| zero_flag | output | 1 | Registered field-is-zero flag |

## Verification
Some properties are checked on every cycle: the one-cycle valid delay, holding of the outputs when no strobe is given, and that test returns the operand. Clear is checked never to raise a bit and set never to drop one. Unsigned extract is checked to flag zero exactly when its result is zero. The generated mask is checked always to contain the offset bit. The exact field placement is shown only by the bench's scenarios: a width code of 0, truncation at bit 31, sign fill from the truncated top bit, the choice of descriptor source, and the reference case of width 5 at offset 10.

// File: rtl/bfu_pkg.sv
// Shared types for the bit-field unit.
// Assumes a 3-bit operation code; values outside the enum act as test.
package bfu_pkg;
    typedef enum logic [2:0] {
        BF_TEST = 3'd0,
        BF_CLR  = 3'd1,
        BF_SET  = 3'd2,
        BF_EXTZ = 3'd3,
        BF_EXTS = 3'd4
    } bf_op_e;
endpackage

// File: rtl/bfu_desc_mux.sv
// Selects the field width code and offset from either the immediates or
// the packed descriptor word (offset in the low IDX_W bits, width code above).
// Assumes both descriptor sources are valid in the same cycle as the strobe.
module bfu_desc_mux #(
    parameter int IDX_W = 5
) (
    input  logic               use_desc_i,
    input  logic [IDX_W-1:0]   imm_width_i,
    input  logic [IDX_W-1:0]   imm_offset_i,
    input  logic [2*IDX_W-1:0] desc_i,
    output logic [IDX_W-1:0]   width_o,
    output logic [IDX_W-1:0]   offset_o
);
    // Pick the descriptor source.
    always_comb begin
        if (use_desc_i) begin
            offset_o = desc_i[IDX_W-1:0];
            width_o  = desc_i[2*IDX_W-1:IDX_W];
        end else begin
            offset_o = imm_offset_i;
            width_o  = imm_width_i;
        end
    end
endmodule

// File: rtl/bfu_mask_gen.sv
// Builds the field mask from a width code and an offset. A width code of 0
// stands for the full word. Field bits above the word are dropped. It also
// gives the bit position of the highest field bit that survives truncation.
// Assumes DATA_W is a power of two and IDX_W = log2(DATA_W).
module bfu_mask_gen #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  width_i,
    input  logic [IDX_W-1:0]  offset_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [IDX_W-1:0]  top_o
);
    localparam int CNT_W  = IDX_W + 1;
    localparam int SPAN_W = IDX_W + 2;

    logic [CNT_W-1:0]  eff_w;
    logic [DATA_W-1:0] ones_low;
    logic [SPAN_W-1:0] span;

    // Effective width 1..DATA_W; code 0 maps to DATA_W.
    assign eff_w = (width_i == '0) ? CNT_W'(DATA_W) : {1'b0, width_i};

    // Right-aligned run of eff_w ones, then moved to the offset.
    assign ones_low = {DATA_W{1'b1}} >> (CNT_W'(DATA_W) - eff_w);
    assign mask_o   = ones_low << offset_i;

    // Highest surviving field bit, clamped to the word's top bit.
    assign span  = SPAN_W'(offset_i) + SPAN_W'(eff_w);
    assign top_o = (span > SPAN_W'(DATA_W)) ? IDX_W'(DATA_W - 1)
                                            : IDX_W'(span - SPAN_W'(1));
endmodule

// File: rtl/bfu_field_core.sv
// Combinational field operations: test, clear, set, zero-filled extract and
// sign-filled extract. The zero flag reflects the incoming field bits.
// Assumes mask_i is a contiguous run starting at offset_i, and top_i is its
// highest bit.
module bfu_field_core #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [IDX_W-1:0]  offset_i,
    input  logic [IDX_W-1:0]  top_i,
    output logic [DATA_W-1:0] result_o,
    output logic              zero_o
);
    import bfu_pkg::*;

    logic [DATA_W-1:0] in_field;
    logic [DATA_W-1:0] field_lo;
    logic [DATA_W-1:0] span_lo;
    logic [DATA_W-1:0] ext_signed;
    logic              sign_bit;

    // Isolate the field and move it down to bit 0.
    assign in_field = operand_i & mask_i;
    assign field_lo = in_field >> offset_i;
    assign span_lo  = mask_i >> offset_i;

    // Fill above the field with its top bit.
    assign sign_bit   = operand_i[top_i];
    assign ext_signed = field_lo | (sign_bit ? ~span_lo : '0);

    // The flag always comes from the incoming field bits.
    assign zero_o = (in_field == '0);

    // Result selection by operation; unknown codes behave as test.
    always_comb begin
        case (bf_op_e'(op_i))
            BF_CLR:  result_o = operand_i & ~mask_i;
            BF_SET:  result_o = operand_i | mask_i;
            BF_EXTZ: result_o = field_lo;
            BF_EXTS: result_o = ext_signed;
            default: result_o = operand_i;
        endcase
    end
endmodule

// File: rtl/bitfield_unit.sv
// Top of the bit-field unit: descriptor select, mask generation, field
// operation and one output register stage. The result and the flag update
// only on a strobe. A synchronous active-low reset clears them.
// Assumes inputs are stable around the rising clock edge.
module bitfield_unit #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         op,
    input  logic [DATA_W-1:0]  operand,
    input  logic               desc_sel,
    input  logic [IDX_W-1:0]   imm_width,
    input  logic [IDX_W-1:0]   imm_offset,
    input  logic [2*IDX_W-1:0] field_desc,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic               zero_flag
);
    import bfu_pkg::*;

    logic [IDX_W-1:0]  sel_width;
    logic [IDX_W-1:0]  sel_offset;
    logic [IDX_W-1:0]  top_pos;
    logic [DATA_W-1:0] fld_mask;
    logic [DATA_W-1:0] core_result;
    logic              core_zero;

    bfu_desc_mux #(.IDX_W(IDX_W)) u_desc (
        .use_desc_i   (desc_sel),
        .imm_width_i  (imm_width),
        .imm_offset_i (imm_offset),
        .desc_i       (field_desc),
        .width_o      (sel_width),
        .offset_o     (sel_offset)
    );

    bfu_mask_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
        .width_i  (sel_width),
        .offset_i (sel_offset),
        .mask_o   (fld_mask),
        .top_o    (top_pos)
    );

    bfu_field_core #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_core (
        .op_i      (op),
        .operand_i (operand),
        .mask_i    (fld_mask),
        .offset_i  (sel_offset),
        .top_i     (top_pos),
        .result_o  (core_result),
        .zero_o    (core_zero)
    );

    // Output stage: valid follows the strobe; data loads only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            zero_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= core_result;
                zero_flag <= core_zero;
            end
        end
    end

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(zero_flag)));
    // R6
    test_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0) |=> (result == $past(operand)));
    // R7
    clear_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1) |=> ((result & ~$past(operand)) == '0));
    // R8
    set_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2) |=> ((result & $past(operand)) == $past(operand)));
    // R11
    extz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3) |=> (zero_flag == (result == '0)));
    // R4
    mask_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> fld_mask[sel_offset]);
endmodule

// File: tb/tb_bitfield_unit.sv
`timescale 1ns/1ps
module tb_bitfield_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] operand = '0;
    logic        desc_sel = 1'b0;
    logic [4:0]  imm_width = '0;
    logic [4:0]  imm_offset = '0;
    logic [9:0]  field_desc = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        zero_flag;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    bitfield_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .operand(operand), .desc_sel(desc_sel), .imm_width(imm_width),
        .imm_offset(imm_offset), .field_desc(field_desc),
        .out_valid(out_valid), .result(result), .zero_flag(zero_flag)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        sel;
        logic [4:0]  w;
        logic [4:0]  off;
        logic [9:0]  desc;
        logic [31:0] opnd;
        logic [31:0] exp_r;
        logic        exp_z;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 5'd5,  5'd10, 10'h3FF, 32'h00007C00, 32'h00007C00, 1'b0, 8'd4},  // R4 ref field w5@10
        '{3'd0, 1'b0, 5'd5,  5'd10, 10'h000, 32'hFFFF83FF, 32'hFFFF83FF, 1'b1, 8'd6},  // R6
        '{3'd1, 1'b0, 5'd5,  5'd10, 10'h000, 32'hFFFFFFFF, 32'hFFFF83FF, 1'b0, 8'd7},  // R7
        '{3'd2, 1'b0, 5'd5,  5'd10, 10'h000, 32'h00000000, 32'h00007C00, 1'b1, 8'd8},  // R8
        '{3'd3, 1'b0, 5'd5,  5'd10, 10'h000, 32'h00005800, 32'h00000016, 1'b0, 8'd9},  // R9
        '{3'd4, 1'b0, 5'd5,  5'd10, 10'h000, 32'h00005800, 32'hFFFFFFF6, 1'b0, 8'd10}, // R10 negative
        '{3'd4, 1'b0, 5'd5,  5'd10, 10'h000, 32'h00002C00, 32'h0000000B, 1'b0, 8'd10}, // R10 positive
        '{3'd3, 1'b0, 5'd0,  5'd0,  10'h000, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 8'd4},  // R4 code 0 = 32 bits
        '{3'd4, 1'b0, 5'd0,  5'd8,  10'h000, 32'h80000000, 32'hFF800000, 1'b0, 8'd5},  // R5 truncated sign
        '{3'd2, 1'b0, 5'd8,  5'd28, 10'h000, 32'h00000000, 32'hF0000000, 1'b1, 8'd5},  // R5 truncated set
        '{3'd1, 1'b1, 5'd1,  5'd0,  {5'd4, 5'd4},  32'hFFFFFFFF, 32'hFFFFFF0F, 1'b0, 8'd3}, // R3
        '{3'd3, 1'b1, 5'd31, 5'd31, {5'd8, 5'd16}, 32'hABCD1234, 32'h000000CD, 1'b0, 8'd3}, // R3
        '{3'd5, 1'b0, 5'd5,  5'd10, 10'h000, 32'h00007C00, 32'h00007C00, 1'b0, 8'd12}, // R12
        '{3'd7, 1'b0, 5'd3,  5'd0,  10'h000, 32'hFFFFFFF8, 32'hFFFFFFF8, 1'b1, 8'd12}, // R12
        '{3'd4, 1'b0, 5'd1,  5'd31, 10'h000, 32'h80000000, 32'hFFFFFFFF, 1'b0, 8'd10}, // R10 one bit
        '{3'd3, 1'b0, 5'd31, 5'd1,  10'h000, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0, 8'd9},  // R9 wide
        '{3'd1, 1'b0, 5'd5,  5'd10, 10'h000, 32'hFFFF83FF, 32'hFFFF83FF, 1'b1, 8'd11}  // R11 clear of zero field
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op         = v.op;
        desc_sel   = v.sel;
        imm_width  = v.w;
        imm_offset = v.off;
        field_desc = v.desc;
        operand    = v.opnd;
    endtask

    // One strobe, then compare the registered outputs one cycle later.
    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
        check(tag, "result", result, v.exp_r);
        check(tag, "zero_flag", {31'd0, zero_flag}, {31'd0, v.exp_z});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog all actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] held;
        // R1: reset with a strobe pending still yields zeros.
        drive(VECS[3]);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "result", result, 32'd0);
        check("R1", "zero_flag", {31'd0, zero_flag}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Table walk over operations, descriptors and boundaries.
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: no strobe, inputs change, outputs hold.
        run_vec(VECS[5]);
        held = result;
        drive(VECS[3]);
        repeat (3) @(negedge clk);
        check("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
        check("R2", "held result", result, held);
        check("R2", "held zero_flag", {31'd0, zero_flag}, 32'd0);

        // R2: back-to-back strobes give one result per cycle.
        @(negedge clk);
        drive(VECS[3]);
        in_valid = 1'b1;
        @(negedge clk);
        check("R8", "b2b first", result, 32'h00007C00);
        drive(VECS[4]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "b2b second", result, 32'h00000016);
        check("R2", "b2b valid", {31'd0, out_valid}, 32'd1);

        // R3: the ignored source does not matter when immediates are selected.
        @(negedge clk);
        drive(VECS[4]);
        field_desc = {5'd8, 5'd16};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3", "desc ignored", result, 32'h00000016);

        // R1: reset in mid-run clears the outputs again.
        @(negedge clk);
        drive(VECS[2]);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "mid reset result", result, 32'd0);
        check("R1", "mid reset valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule